// File: doc/BRIEF.md
# Dual Framebuffer Scanout Address Sequencer

This block generates the memory read address stream for a raster display. It scans two separately programmed framebuffer windows, each described by a start address and an exclusive end address. The end address is the start plus the number of active lines times the line pitch in bytes. The stream is issued as burst requests with a valid/ready handshake. When dual mode is on, the block reads window 0, then window 1, then window 0 again, and keeps alternating. When dual mode is off, it rescans window 0 on every frame.

Each window has its own end-of-frame status bit. Software can therefore tell which window just finished and rewrite that window's addresses while the other one is being read. A window's addresses are copied into the working counters only when that window's frame begins, so a write during a frame cannot disturb the frame in progress.

The status bits are sticky, and software clears them by writing ones. Two further status bits capture display error events from outside the block. A masked OR of the status bits drives an interrupt line. The same register port also holds a pixel-FIFO threshold, which sets the fill level at which pixel data may be released downstream.

Top module: `dual_fb_scanout`

## Requirements
- R1: After reset no request is issued, the interrupt is low and every register reads zero.
- R2: With run (CTRL bit 0, register 0) and dual (CTRL bit 1) set, frames alternate window 0, window 1, window 0. Window 0 uses start register 4 and end register 5. Window 1 uses start register 6 and end register 7.
- R3: With run set and dual clear, every frame reads window 0.
- R4: Finishing a window 0 frame sets status bit 0 and finishing a window 1 frame sets status bit 1 (status is register 1).
- R5: Burst code CTRL[4:2] values 0 to 4 select 1, 2, 4, 8 or 16 words per request. A CTRL write that carries a code of 5, 6 or 7 is ignored as a whole.
- R6: Each accepted request advances the address by its length times 4 bytes. The address holds while a request waits for ready. The last request of a frame is shortened so that it ends exactly at the end address.
- R7: A window's start and end registers are sampled only when that window's frame begins. A write made earlier in the frame takes effect the next time that window starts.
- R8: Status bits are sticky and clear where a one is written to register 1. A new event wins over a clear in the same cycle. The sync-lost input sets bit 2 and the underflow input sets bit 3.
- R9: The interrupt output is high exactly when some status bit and the same bit of the mask register (register 2) are both set.
- R10: Clearing run stops requests from the next cycle on. Setting run again restarts at window 0.
- R11: The release output is high exactly when the FIFO level is at least the threshold field CTRL[12:8].
- R12: Start and end registers are word aligned: bits 1:0 always read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index for write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| sync_lost_evt | input | 1 | Sync-lost event pulse |
| underflow_evt | input | 1 | FIFO underflow event pulse |
| req_valid | output | 1 | Burst request valid |
| req_ready | input | 1 | Burst request accepted by memory |
| req_addr | output | 32 | Byte address of the burst |
| req_len | output | 5 | Burst length in words |
| fifo_level | input | 5 | Current pixel FIFO fill level |
| px_release | output | 1 | Pixel release permitted |
| irq | output | 1 | Masked interrupt |

## Verification
The bench builds the block with its default parameters: 32-bit addresses and data, a 5-bit request length and a 5-bit FIFO level. With these values every burst code up to 16 words can be reached, as can a threshold equal to the FIFO level under test. The windows are sized so that the final burst of a frame is shortened. Ready is stalled in a fixed rhythm during one run, and the window registers are rewritten in the middle of a frame, so the hold and latching rules are exercised against a per-clock reference model.

// File: rtl/scan_pkg.sv
package scan_pkg;
   localparam int unsigned RA_W = 3;
   localparam logic [RA_W-1:0] RG_CTRL  = 3'd0;
   localparam logic [RA_W-1:0] RG_STAT  = 3'd1;
   localparam logic [RA_W-1:0] RG_MASK  = 3'd2;
   localparam logic [RA_W-1:0] RG_WIN0S = 3'd4;
   localparam int unsigned STAT_W   = 4;
   localparam int unsigned CODE_MAX = 4;
   localparam int unsigned THR_LSB  = 8;
   localparam int unsigned WB_LOG   = 2;

   typedef enum logic [1:0] {
      SQ_IDLE = 2'd0,
      SQ_LOAD = 2'd1,
      SQ_RUN  = 2'd2
   } sq_state_e;
endpackage

// File: rtl/scan_regs.sv
module scan_regs
   import scan_pkg::*;
#(
   parameter int unsigned AW    = 32,
   parameter int unsigned LVL_W = 5
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [RA_W-1:0]      addr,
   input  logic [AW-1:0]        wdata,
   output logic [AW-1:0]        rdata,
   input  logic [1:0]           eof_evt,
   input  logic                 sync_lost_evt,
   input  logic                 underflow_evt,
   output logic                 run,
   output logic                 dual,
   output logic [2:0]           burst_code,
   output logic [LVL_W-1:0]     thresh,
   output logic [1:0][AW-1:0]   win_start,
   output logic [1:0][AW-1:0]   win_end,
   output logic                 irq
);
   if (THR_LSB + LVL_W > AW) begin : g_bad_thr
      $error("threshold field does not fit the register width");
   end

   logic [STAT_W-1:0] stat_q, mask_q, stat_set, stat_clr;
   logic              ctrl_ok;

   assign ctrl_ok  = (wdata[4:2] <= 3'(CODE_MAX));
   assign stat_set = {underflow_evt, sync_lost_evt, eof_evt};
   assign stat_clr = (wr_en && addr == RG_STAT) ? wdata[STAT_W-1:0] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run        <= 1'b0;
         dual       <= 1'b0;
         burst_code <= '0;
         thresh     <= '0;
         mask_q     <= '0;
         stat_q     <= '0;
      end else begin
         if (wr_en && addr == RG_CTRL && ctrl_ok) begin
            run        <= wdata[0];
            dual       <= wdata[1];
            burst_code <= wdata[4:2];
            thresh     <= wdata[THR_LSB +: LVL_W];
         end
         if (wr_en && addr == RG_MASK) mask_q <= wdata[STAT_W-1:0];
         stat_q <= (stat_q & ~stat_clr) | stat_set;
      end
   end

   for (genvar s = 0; s < 2; s++) begin : g_win
      localparam logic [RA_W-1:0] A_START = RG_WIN0S + RA_W'(2 * s);
      localparam logic [RA_W-1:0] A_END   = RG_WIN0S + RA_W'(2 * s + 1);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            win_start[s] <= '0;
            win_end[s]   <= '0;
         end else if (wr_en) begin
            if (addr == A_START) win_start[s] <= {wdata[AW-1:WB_LOG], {WB_LOG{1'b0}}};
            if (addr == A_END)   win_end[s]   <= {wdata[AW-1:WB_LOG], {WB_LOG{1'b0}}};
         end
      end

      assert_eof_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
         eof_evt[s] |=> stat_q[s]);
   end

   for (genvar b = 0; b < STAT_W; b++) begin : g_sticky
      assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
         (stat_q[b] && !(wr_en && addr == RG_STAT && wdata[b])) |=> stat_q[b]);
   end

   assert_code_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
      burst_code <= 3'(CODE_MAX));

   always_comb begin
      rdata = '0;
      case (addr)
         RG_CTRL: begin
            rdata[0]                 = run;
            rdata[1]                 = dual;
            rdata[4:2]               = burst_code;
            rdata[THR_LSB +: LVL_W]  = thresh;
         end
         RG_STAT: rdata[STAT_W-1:0] = stat_q;
         RG_MASK: rdata[STAT_W-1:0] = mask_q;
         3'd4:    rdata = win_start[0];
         3'd5:    rdata = win_end[0];
         3'd6:    rdata = win_start[1];
         3'd7:    rdata = win_end[1];
         default: rdata = '0;
      endcase
   end

   assign irq = |(stat_q & mask_q);
endmodule

// File: rtl/scan_seq.sv
module scan_seq
   import scan_pkg::*;
#(
   parameter int unsigned AW    = 32,
   parameter int unsigned LEN_W = 5
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 run,
   input  logic                 dual,
   input  logic [2:0]           burst_code,
   input  logic [1:0][AW-1:0]   win_start,
   input  logic [1:0][AW-1:0]   win_end,
   input  logic                 req_ready,
   output logic                 req_valid,
   output logic [AW-1:0]        req_addr,
   output logic [LEN_W-1:0]     req_len,
   output logic [1:0]           eof_evt
);
   if (LEN_W < 5) begin : g_bad_len
      $error("length width must hold a 16-word burst");
   end

   sq_state_e        st_q;
   logic             slot_q;
   logic [AW-1:0]    cur_q, lim_q, rem_words, step;
   logic [LEN_W-1:0] burst_words;
   logic             in_run, at_end;

   assign in_run      = (st_q == SQ_RUN) && run;
   assign at_end      = in_run && (cur_q >= lim_q);
   assign burst_words = LEN_W'(1) << burst_code;
   assign rem_words   = (lim_q - cur_q) >> WB_LOG;
   assign req_len     = (rem_words < AW'(burst_words)) ? rem_words[LEN_W-1:0] : burst_words;
   assign req_valid   = in_run && !(cur_q >= lim_q);
   assign req_addr    = cur_q;
   assign step        = AW'(req_len) << WB_LOG;
   assign eof_evt     = at_end ? (slot_q ? 2'b10 : 2'b01) : 2'b00;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= SQ_IDLE;
         slot_q <= 1'b0;
         cur_q  <= '0;
         lim_q  <= '0;
      end else if (!run) begin
         st_q <= SQ_IDLE;
      end else begin
         case (st_q)
            SQ_IDLE: begin
               st_q   <= SQ_LOAD;
               slot_q <= 1'b0;
            end
            SQ_LOAD: begin
               cur_q <= win_start[slot_q];
               lim_q <= win_end[slot_q];
               st_q  <= SQ_RUN;
            end
            SQ_RUN: begin
               if (at_end) begin
                  slot_q <= dual ? ~slot_q : 1'b0;
                  st_q   <= SQ_LOAD;
               end else if (req_valid && req_ready) begin
                  cur_q <= cur_q + step;
               end
            end
            default: st_q <= SQ_IDLE;
         endcase
      end
   end

   assert_no_ceiling_cross_R6: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> ({1'b0, req_addr} + {1'b0, step}) <= {1'b0, lim_q});

   assert_hold_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_ready) |=> $stable(req_addr));

   assert_len_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> (req_len != '0) && (req_len <= burst_words));

   assert_restart_slot0_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == SQ_IDLE && run) |=> (st_q == SQ_LOAD && !slot_q));
endmodule

// File: rtl/scan_fifo_gate.sv
module scan_fifo_gate #(
   parameter int unsigned LVL_W = 5
) (
   input  logic [LVL_W-1:0] fifo_level,
   input  logic [LVL_W-1:0] thresh,
   output logic             px_release
);
   if (LVL_W < 1 || LVL_W > 16) begin : g_bad_lvl
      $error("FIFO level width out of range");
   end

   assign px_release = (fifo_level >= thresh);

   always_comb begin
      assert_release_R11: assert (px_release == !(fifo_level < thresh));
   end
endmodule

// File: rtl/dual_fb_scanout.sv
module dual_fb_scanout
   import scan_pkg::*;
#(
   parameter int unsigned AW    = 32,
   parameter int unsigned LEN_W = 5,
   parameter int unsigned LVL_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr_en,
   input  logic [RA_W-1:0]   reg_addr,
   input  logic [AW-1:0]     reg_wdata,
   output logic [AW-1:0]     reg_rdata,
   input  logic              sync_lost_evt,
   input  logic              underflow_evt,
   output logic              req_valid,
   input  logic              req_ready,
   output logic [AW-1:0]     req_addr,
   output logic [LEN_W-1:0]  req_len,
   input  logic [LVL_W-1:0]  fifo_level,
   output logic              px_release,
   output logic              irq
);
   logic                run, dual;
   logic [2:0]          burst_code;
   logic [LVL_W-1:0]    thresh;
   logic [1:0][AW-1:0]  win_start, win_end;
   logic [1:0]          eof_evt;

   scan_regs #(.AW(AW), .LVL_W(LVL_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .addr(reg_addr),
      .wdata(reg_wdata), .rdata(reg_rdata), .eof_evt(eof_evt),
      .sync_lost_evt(sync_lost_evt), .underflow_evt(underflow_evt),
      .run(run), .dual(dual), .burst_code(burst_code), .thresh(thresh),
      .win_start(win_start), .win_end(win_end), .irq(irq)
   );

   scan_seq #(.AW(AW), .LEN_W(LEN_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .run(run), .dual(dual),
      .burst_code(burst_code), .win_start(win_start), .win_end(win_end),
      .req_ready(req_ready), .req_valid(req_valid), .req_addr(req_addr),
      .req_len(req_len), .eof_evt(eof_evt)
   );

   scan_fifo_gate #(.LVL_W(LVL_W)) u_gate (
      .fifo_level(fifo_level), .thresh(thresh), .px_release(px_release)
   );

   assert_irq_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(eof_evt != 2'b00 || sync_lost_evt || underflow_evt
                           || (reg_wr_en && reg_addr == RG_MASK)));
endmodule

// File: tb/tb_dual_fb_scanout.sv
module tb_dual_fb_scanout;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr_en = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        sync_lost_evt = 1'b0, underflow_evt = 1'b0;
   logic        req_valid, req_ready = 1'b1;
   logic [31:0] req_addr;
   logic [4:0]  req_len;
   logic [4:0]  fifo_level = '0;
   logic        px_release, irq;

   dual_fb_scanout dut (
      .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .sync_lost_evt(sync_lost_evt), .underflow_evt(underflow_evt),
      .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
      .req_len(req_len), .fifo_level(fifo_level), .px_release(px_release),
      .irq(irq)
   );

   always #5 clk = ~clk;

   int n_vec = 0, n_bad = 0;
   bit finished = 0;
   int rmode = 0, rcnt = 0;
   longint acc_addr[$];
   int     acc_len[$];

   task automatic chk(input string tag, input longint act, input longint exp);
      n_vec++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   int     m_st = 0, m_slot = 0, m_code = 0, m_thr = 0, m_mask = 0, m_sts = 0;
   bit     m_run = 0, m_dual = 0;
   longint m_cur = 0, m_lim = 0;
   longint m_start[2] = '{0, 0};
   longint m_end[2]   = '{0, 0};

   function automatic bit m_valid();
      return (m_st == 2) && m_run && (m_cur < m_lim);
   endfunction

   function automatic int m_len();
      longint rem = (m_lim - m_cur) / 4;
      int bw = 1 << m_code;
      return (rem < bw) ? int'(rem) : bw;
   endfunction

   function automatic longint m_read(input int a);
      case (a)
         0: return longint'(m_run) | (longint'(m_dual) << 1) | (longint'(m_code) << 2) | (longint'(m_thr) << 8);
         1: return m_sts;
         2: return m_mask;
         4: return m_start[0];
         5: return m_end[0];
         6: return m_start[1];
         7: return m_end[1];
         default: return 0;
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_st = 0; m_slot = 0; m_cur = 0; m_lim = 0; m_run = 0; m_dual = 0;
         m_code = 0; m_thr = 0; m_mask = 0; m_sts = 0;
         m_start = '{0, 0}; m_end = '{0, 0};
      end else begin
         bit v, done;
         int l, dslot, setb, clr;
         v = m_valid(); l = m_len();
         done = (m_st == 2) && m_run && (m_cur >= m_lim);
         dslot = m_slot;
         if (!m_run) m_st = 0;
         else if (m_st == 0) begin m_st = 1; m_slot = 0; end
         else if (m_st == 1) begin m_cur = m_start[m_slot]; m_lim = m_end[m_slot]; m_st = 2; end
         else if (done) begin m_slot = m_dual ? 1 - m_slot : 0; m_st = 1; end
         else if (v && req_ready) m_cur = m_cur + l * 4;
         setb = (done ? (1 << dslot) : 0) | (sync_lost_evt ? 4 : 0) | (underflow_evt ? 8 : 0);
         clr = (reg_wr_en && reg_addr == 1) ? int'(reg_wdata[3:0]) : 0;
         m_sts = (m_sts & ~clr) | setb;
         if (reg_wr_en) begin
            case (reg_addr)
               0: if (reg_wdata[4:2] <= 3'd4) begin
                     m_run = reg_wdata[0]; m_dual = reg_wdata[1];
                     m_code = int'(reg_wdata[4:2]); m_thr = int'(reg_wdata[12:8]);
                  end
               2: m_mask = int'(reg_wdata[3:0]);
               4: m_start[0] = reg_wdata & 32'hFFFF_FFFC;
               5: m_end[0]   = reg_wdata & 32'hFFFF_FFFC;
               6: m_start[1] = reg_wdata & 32'hFFFF_FFFC;
               7: m_end[1]   = reg_wdata & 32'hFFFF_FFFC;
               default: ;
            endcase
         end
      end
   end

   // per-clock comparison, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         chk("R6 req_valid", req_valid, m_valid());
         if (m_valid()) begin
            chk("R6 req_addr", req_addr, m_cur);
            chk("R5 req_len", req_len, m_len());
         end
         chk("R9 irq", irq, (m_sts & m_mask) != 0);
         chk("R11 px_release", px_release, int'(fifo_level) >= m_thr);
         chk("R8 reg_rdata", reg_rdata, m_read(int'(reg_addr)));
      end
   end

   // record accepted requests at the port
   always @(posedge clk) begin
      if (rst_n && req_valid && req_ready) begin
         acc_addr.push_back(longint'(req_addr));
         acc_len.push_back(int'(req_len));
      end
   end

   // memory-side ready pattern
   initial begin
      forever begin
         @(negedge clk); #1;
         rcnt++;
         req_ready = (rmode == 0) ? 1'b1 : ((rcnt % 3) != 0);
      end
   end

   task automatic wr(input int a, input longint d);
      @(negedge clk); #1;
      reg_wr_en = 1'b1; reg_addr = 3'(a); reg_wdata = 32'(d);
      @(posedge clk); #1;
      reg_wr_en = 1'b0;
   endtask

   task automatic rd(input int a, output longint d);
      @(negedge clk); #1;
      reg_addr = 3'(a);
      @(negedge clk);
      d = longint'(reg_rdata);
   endtask

   task automatic idle(input int n);
      repeat (n) @(posedge clk);
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog R1 actual=running expected=finished");
      summary();
   end

   initial begin
      longint d;
      repeat (3) @(negedge clk);
      #1 rst_n = 1'b1;
      // R1: reset state
      @(negedge clk);
      chk("R1 req_valid after reset", req_valid, 0);
      chk("R1 irq after reset", irq, 0);
      rd(1, d); chk("R1 status after reset", d, 0);
      rd(0, d); chk("R1 ctrl after reset", d, 0);

      // program both windows; R12 alignment
      wr(4, 'h1000); wr(5, 'h1040);
      wr(6, 'h2002); wr(7, 'h2028);
      rd(6, d); chk("R12 start low bits dropped", d, 'h2000);
      wr(2, 'h3);
      acc_addr.delete(); acc_len.delete();
      wr(0, 'h80B);               // run, dual, 4-word bursts, threshold 8
      idle(40);
      chk("R2 first frame window 0", acc_addr[0], 'h1000);
      chk("R6 advance by burst", acc_addr[3], 'h1030);
      chk("R2 second frame window 1", acc_addr[4], 'h2000);
      chk("R6 truncated last burst addr", acc_addr[6], 'h2020);
      chk("R6 truncated last burst len", acc_len[6], 2);
      chk("R2 third frame window 0", acc_addr[7], 'h1000);
      rd(1, d); chk("R4 both window flags set", d & 3, 3);
      @(negedge clk); chk("R9 irq from masked eof", irq, 1);

      // R10 stop, R8 clear
      wr(0, 'h80A);
      chk("R10 no request after run cleared", req_valid, 0);
      wr(1, 'hF);
      rd(1, d); chk("R8 write-one clear", d, 0);
      @(negedge clk); chk("R9 irq low after clear", irq, 0);

      // R5 illegal code rejected
      wr(0, 'h815);
      rd(0, d); chk("R5 illegal code write ignored", d, 'h80A);
      idle(4);
      @(negedge clk); chk("R5 still idle after illegal write", req_valid, 0);

      // R3 dual off, 16-word bursts; R10 restart at window 0
      acc_addr.delete(); acc_len.delete();
      wr(0, 'h811);
      idle(30);
      chk("R10 restart at window 0", acc_addr[0], 'h1000);
      chk("R3 single window repeat", acc_addr[1], 'h1000);
      chk("R3 single window repeat 2", acc_addr[2], 'h1000);
      chk("R5 16-word burst", acc_len[0], 16);

      // R8 error events, R9 mask
      wr(2, 'h0);
      @(negedge clk); #1 sync_lost_evt = 1'b1; underflow_evt = 1'b1;
      @(posedge clk); #1 sync_lost_evt = 1'b0; underflow_evt = 1'b0;
      rd(1, d); chk("R8 error event bits", (d >> 2) & 3, 3);
      @(negedge clk); chk("R9 irq masked off", irq, 0);
      wr(2, 'h4);
      @(negedge clk); chk("R9 irq on sync-lost mask", irq, 1);
      wr(0, 'h810);
      wr(1, 'hF);
      rd(1, d); chk("R8 cleared after recovery", d, 0);

      // R7 mid-frame rewrite, 1-word bursts with stalls
      rmode = 1;
      acc_addr.delete(); acc_len.delete();
      wr(0, 'h803);
      idle(5);
      wr(4, 'h5000); wr(5, 'h5010);
      wr(6, 'h3000); wr(7, 'h3008);
      idle(80);
      chk("R7 current frame unaffected", acc_addr[15], 'h103C);
      chk("R7 window 1 new start", acc_addr[16], 'h3000);
      chk("R7 window 1 new second", acc_addr[17], 'h3004);
      chk("R7 window 0 new start next frame", acc_addr[18], 'h5000);
      wr(0, 'h802);
      rmode = 0;

      // R11 threshold compare
      @(negedge clk); #1 fifo_level = 5'd7;
      @(negedge clk); chk("R11 below threshold", px_release, 0);
      #1 fifo_level = 5'd8;
      @(negedge clk); chk("R11 at threshold", px_release, 1);
      idle(2);
      summary();
   end
endmodule